// File: doc/BRIEF.md
# Gated Asynchronous Serial Transmitter with Break

This block is the transmit side of a programmable serial port. The CPU offers a character over an 8-bit write stream (`wr_valid` / `wr_data` / `wr_ready`). The block keeps the character in a one-entry holding register, and a shifter then sends it on `txd` as an asynchronous frame. A frame is a low start bit, 5 to 8 data bits with the least significant bit first, an optional even or odd parity bit, and one or two high stop bits. Each bit lasts 1, 16 or 64 pulses of the transmit-clock enable `txc_en`.

A write is stored only while the transmitter is enabled, which means `cmd_tx_en` is high and the active-low clear-to-send input `cts_n` is low. A write offered while the transmitter is disabled still completes its handshake, but the block throws the character away. Once a character has been stored, it is sent in full even if the transmitter is disabled afterwards. A break command pulls the line low for as long as it is held. The `tx_empty` output reports that nothing is waiting and nothing is shifting.

Back-pressure: `wr_ready` is high exactly when the holding register is free. A transfer takes place on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the writer must hold `wr_valid` and `wr_data` steady.

Top module: `sertx_gated`

## Requirements
- R1: While reset is applied and after it is released, `txd` is high, `wr_ready` is high and `tx_empty` is high.
- R2: A frame is a 0 start bit, then `5+cfg_len` data bits sent LSB first, then (if `cfg_par_en`=1) one parity bit, then one stop bit at 1, or two stop bits at 1 if `cfg_stop2`=1.
- R3: The parity bit makes the number of ones across the data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R4: Each bit lasts F pulses of `txc_en`. `cfg_factor` 2'b00 gives F=1, 2'b01 gives F=16, and 2'b10 or 2'b11 gives F=64. `txd` changes only on clock edges where `txc_en` is high, except when it is forced by break.
- R5: A write accepted while `cmd_tx_en`=0 or `cts_n`=1 is discarded. `tx_empty` stays high and `txd` stays high.
- R6: A character stored while the transmitter is enabled is sent in full, even if `cmd_tx_en` falls or `cts_n` rises afterwards. This holds both for the character being shifted and for the character in the holding register.
- R7: While `cmd_break`=1, `txd` is low in the same cycle. When `cmd_break` returns to 0, the line goes back to the level it would otherwise have.
- R8: `wr_ready` is low while the holding register holds a character. It becomes free only on a `txc_en` edge that moves the character into the shifter. `tx_empty` is high only when the holding register is empty and no frame is being shifted. It returns high on the edge that ends the last stop bit.
- R9: If a character is waiting when the last stop bit ends, its start bit follows with no idle bit in between.
- R10: When the line is idle and `txc_en` is high on every cycle, the start bit appears on `txd` one clock edge after the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txc_en | input | 1 | Transmit-clock enable pulse; one pulse is one baud sub-tick |
| cfg_factor | input | 2 | Baud factor select: 00 gives 1x, 01 gives 16x, 1x gives 64x |
| cfg_len | input | 2 | Number of data bits minus 5 |
| cfg_par_en | input | 1 | Adds a parity bit to the frame |
| cfg_par_odd | input | 1 | Parity sense: 1 for odd, 0 for even |
| cfg_stop2 | input | 1 | Sends two stop bits instead of one |
| cmd_tx_en | input | 1 | Command bit that enables the transmitter |
| cmd_break | input | 1 | Command bit that forces the line low |
| cts_n | input | 1 | Clear to send, active low |
| wr_valid | input | 1 | Write stream: a character is offered |
| wr_data | input | 8 | Write stream: the character |
| wr_ready | output | 1 | Write stream: the holding register is free |
| txd | output | 1 | Serial line |
| tx_empty | output | 1 | No character is waiting and no frame is being shifted |

## Verification
With `txc_en` high on every cycle, a write offered at one falling edge is accepted at the next rising edge. `wr_ready` reads low at the falling edge after that, and the start bit is on `txd` one falling edge later. From that point the bench samples every falling edge of the frame: bit k must hold for falling edges k·F through k·F+F−1. `tx_empty` and a high line are checked at falling edge n·F. In a back-to-back pair, the next start bit is checked at that same falling edge. Break and the outcome of a discarded write are combinational or need no edge at all, so the bench checks them at the next falling edge and keeps watching the line for a long window afterwards.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FAC_X1   = 2'b00,
    FAC_X16  = 2'b01,
    FAC_X64  = 2'b10,
    FAC_X64B = 2'b11
  } fac_e;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int MID_FACTOR = 16,
  parameter int MAX_FACTOR = 64,
  localparam int TICK_W = $clog2(MAX_FACTOR)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txc_en,
  input  logic       busy,
  input  logic       take,
  input  logic [1:0] factor,
  output logic       bit_end
);
  import sertx_pkg::*;

  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] last_tick;

  always_comb begin
    case (fac_e'(factor))
      FAC_X1:  last_tick = '0;
      FAC_X16: last_tick = TICK_W'(MID_FACTOR - 1);
      default: last_tick = TICK_W'(MAX_FACTOR - 1);
    endcase
  end

  assign bit_end = busy && txc_en && (tick_q == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tick_q <= '0;
    else if (!busy || take)      tick_q <= '0;
    else if (bit_end)            tick_q <= '0;
    else if (txc_en)             tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  localparam int LEN_W   = $clog2(DATA_W - MIN_BITS + 1),
  localparam int FRAME_W = DATA_W + 4,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [LEN_W-1:0]   len_sel,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               stop2,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  int  nd;
  logic par;

  always_comb begin
    nd    = MIN_BITS + int'(len_sel);
    frame = '1;
    frame[0] = 1'b0;
    par   = par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame[1+i] = data[i];
        par        = par ^ data[i];
      end
    end
    if (par_en) frame[1+nd] = par;
    nbits = CNT_W'(2 + nd + (par_en ? 1 : 0) + (stop2 ? 1 : 0));
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int FRAME_W = 12,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               txc_en,
  input  logic               bit_end,
  input  logic               pending,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               busy,
  output logic               take,
  output logic               line
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               last_bit;

  assign last_bit = (left_q == CNT_W'(1));
  assign take     = txc_en && pending && (!busy || (bit_end && last_bit));
  assign line     = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (take) begin
      sh_q   <= frame_in;
      left_q <= nbits_in;
      busy   <= 1'b1;
    end else if (bit_end) begin
      if (last_bit) begin
        busy <= 1'b0;
        sh_q <= '1;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_gated.sv
module sertx_gated #(
  parameter int DATA_W     = 8,
  parameter int MIN_BITS   = 5,
  parameter int MID_FACTOR = 16,
  parameter int MAX_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txc_en,
  input  logic [1:0]        cfg_factor,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cmd_tx_en,
  input  logic              cmd_break,
  input  logic              cts_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              txd,
  output logic              tx_empty
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic               hold_full;
  logic               tx_on;
  logic               busy, take, bit_end, line;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign tx_on    = cmd_tx_en && !cts_n;
  assign wr_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (wr_valid && wr_ready && tx_on) begin
      hold_full <= 1'b1;
      hold_q    <= wr_data;
    end
  end

  sertx_framer #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_framer (
    .data(hold_q), .len_sel(cfg_len), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .stop2(cfg_stop2), .frame(frame), .nbits(nbits)
  );

  sertx_baud #(.MID_FACTOR(MID_FACTOR), .MAX_FACTOR(MAX_FACTOR)) u_baud (
    .clk(clk), .rst_n(rst_n), .txc_en(txc_en), .busy(busy), .take(take),
    .factor(cfg_factor), .bit_end(bit_end)
  );

  sertx_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .txc_en(txc_en), .bit_end(bit_end),
    .pending(hold_full), .frame_in(frame), .nbits_in(nbits),
    .busy(busy), .take(take), .line(line)
  );

  assign txd      = cmd_break ? 1'b0 : line;
  assign tx_empty = !hold_full && !busy;
endmodule

// File: rtl/sertx_gated_chk.sv
module sertx_gated_chk (
  input logic clk,
  input logic rst_n,
  input logic txc_en,
  input logic cmd_tx_en,
  input logic cmd_break,
  input logic cts_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic txd,
  input logic tx_empty
);
  // R7
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_break |-> !txd);

  // R5
  drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (!cmd_tx_en || cts_n) && tx_empty) |=> tx_empty);

  // R6
  store_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cmd_tx_en && !cts_n) |=> !tx_empty);

  // R8
  hold_until_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !txc_en) |=> !wr_ready);

  // R4
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_break && !$past(cmd_break) && !$past(txc_en)) |-> $stable(txd));

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !cmd_break) |-> txd);
endmodule

bind sertx_gated sertx_gated_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txc_en(txc_en), .cmd_tx_en(cmd_tx_en),
  .cmd_break(cmd_break), .cts_n(cts_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .txd(txd), .tx_empty(tx_empty)
);

// File: tb/sertx_gated_bench.sv
module sertx_gated_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txc_en = 1'b1;
  logic [1:0] cfg_factor = 2'b00;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       cmd_tx_en = 1'b1, cmd_break = 1'b0, cts_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, txd, tx_empty;

  int checks = 0, fails = 0;
  logic div_mode = 1'b0;
  int   div_cnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    div_cnt <= (div_cnt == 2) ? 0 : div_cnt + 1;
    txc_en  <= div_mode ? (div_cnt == 2) : 1'b1;
  end

  sertx_gated u_sertx_gated (
    .clk(clk), .rst_n(rst_n), .txc_en(txc_en), .cfg_factor(cfg_factor),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cmd_tx_en(cmd_tx_en), .cmd_break(cmd_break),
    .cts_n(cts_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, output int n);
    logic [11:0] f;
    int nd, idx;
    logic p;
    f = '1; f[0] = 1'b0; nd = 5 + int'(cfg_len);
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin f[1+i] = d[i]; p = p ^ d[i]; end
    idx = nd + 1;
    if (cfg_par_en) begin f[idx] = cfg_par_odd ? ~p : p; idx++; end
    n = idx + 1 + (cfg_stop2 ? 1 : 0);
    return f;
  endfunction

  function automatic int fac_val();
    return (cfg_factor == 2'b00) ? 1 : (cfg_factor == 2'b01) ? 16 : 64;
  endfunction

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Starts at a falling edge; ends on the last falling edge of the frame.
  task automatic capture(input logic [7:0] d, input int f, input string tag);
    logic [11:0] e;
    int n, waited, bad_i, bad_v, bad_e;
    e = exp_frame(d, n);
    waited = 0;
    while (txd !== 1'b0 && waited < 400) begin @(negedge clk); waited++; end
    bad_i = -1; bad_v = 0; bad_e = 0;
    for (int idx = 0; idx < n * f; idx++) begin
      if (idx > 0) @(negedge clk);
      if (txd !== e[idx/f] && bad_i < 0) begin
        bad_i = idx; bad_v = int'(txd); bad_e = int'(e[idx/f]);
      end
    end
    chk(bad_i < 0, tag, bad_v, bad_e);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] dv;
    int n, f;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && wr_ready === 1'b1 && tx_empty === 1'b1, "R1 in reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && wr_ready === 1'b1 && tx_empty === 1'b1, "R1 after reset",
        int'({txd, wr_ready, tx_empty}), 7);

    // R2 R3 R10: sweep of lengths, parity modes, stop counts and data at 1x
    for (int l = 0; l < 4; l++)
      for (int pm = 0; pm < 3; pm++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 256; d += 3) begin
            cfg_len = 2'(l); cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
            cfg_stop2 = s[0];
            dv = 8'(d);
            @(negedge clk);
            wr_valid = 1'b1; wr_data = dv;
            @(negedge clk);
            wr_valid = 1'b0;
            if (d == 0) chk(wr_ready === 1'b0 && txd === 1'b1, "R8 ready low after accept",
                            int'(wr_ready), 0);
            @(negedge clk);
            if (d == 0) chk(txd === 1'b0, "R10 start one edge after accept", int'(txd), 0);
            capture(dv, 1, "R2 R3 frame at 1x");
            @(negedge clk);
            if (d == 0) chk(tx_empty === 1'b1 && txd === 1'b1, "R8 empty after last stop",
                            int'(tx_empty), 1);
          end

    // R4 factors 16 and 64, then divided enable at 1x
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop2 = 1'b1;
    for (int fs = 1; fs < 4; fs++) begin
      cfg_factor = 2'(fs);
      f = fac_val();
      put(8'h96);
      capture(8'h96, f, "R4 bit length at factor");
      @(negedge clk);
      chk(tx_empty === 1'b1, "R4 empty after slow frame", int'(tx_empty), 1);
    end
    cfg_factor = 2'b00;
    div_mode = 1'b1;
    repeat (6) @(negedge clk);
    fork
      put(8'h5B);
      capture(8'h5B, 3, "R4 one bit per three-cycle enable");
    join
    div_mode = 1'b1;
    repeat (3) @(negedge clk);
    div_mode = 1'b0;
    repeat (3) @(negedge clk);

    // R9 back-to-back, R8 ready while holding
    cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    put(8'hC3);
    fork
      begin
        capture(8'hC3, 1, "R9 first of pair");
        @(negedge clk);
        chk(txd === 1'b0, "R9 no idle before second start", int'(txd), 0);
        capture(8'h2D, 1, "R9 second of pair");
      end
      begin
        put(8'h2D);
        chk(wr_ready === 1'b0 && tx_empty === 1'b0, "R8 holding full during shift",
            int'(wr_ready), 0);
      end
    join
    @(negedge clk);
    chk(tx_empty === 1'b1, "R8 empty after pair", int'(tx_empty), 1);

    // R5 writes while disabled
    cmd_tx_en = 1'b0;
    put(8'h00);
    chk(wr_ready === 1'b1 && tx_empty === 1'b1, "R5 dropped when command off",
        int'(tx_empty), 1);
    begin
      int lows = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk(lows == 0, "R5 line stays mark when command off", lows, 0);
    end
    cmd_tx_en = 1'b1; cts_n = 1'b1;
    put(8'h00);
    chk(tx_empty === 1'b1, "R5 dropped when clear-to-send high", int'(tx_empty), 1);
    begin
      int lows = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
      chk(lows == 0, "R5 line stays mark when clear-to-send high", lows, 0);
    end
    cts_n = 1'b0;

    // R6 disable after storing two characters
    put(8'hE1);
    fork
      begin
        capture(8'hE1, 1, "R6 shifting char survives disable");
        @(negedge clk);
        capture(8'h74, 1, "R6 held char survives disable");
      end
      begin
        put(8'h74);
        cts_n = 1'b1; cmd_tx_en = 1'b0;
      end
    join
    @(negedge clk);
    chk(tx_empty === 1'b1 && txd === 1'b1, "R6 idle after committed chars",
        int'(tx_empty), 1);
    cts_n = 1'b0; cmd_tx_en = 1'b1;

    // R7 break
    cmd_break = 1'b1;
    begin
      int highs = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (txd !== 1'b0) highs++; end
      chk(highs == 0, "R7 break holds line low", highs, 0);
    end
    cmd_break = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R7 line returns to mark", int'(txd), 1);
    cmd_tx_en = 1'b0; cmd_break = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R7 break while disabled", int'(txd), 0);
    cmd_break = 1'b0; cmd_tx_en = 1'b1;
    @(negedge clk);
    n = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule